// File: doc/BRIEF.md
# Time-Compare Periodic Pulse Channel

This block is one output channel of a timing subsystem. It watches a shared 64-bit nanosecond time base and, once that time reaches a start value programmed by software, drives a square wave. The period of the square wave is given in cycles of the reference clock that also clocks the channel. Software controls the channel through a small write-only register port. The port has a 64-bit start time split into two 32-bit words, a period length, a control word that sets the output polarity, and a signed nudge that moves later edges by a few cycles.

A length of zero keeps the channel idle. The normal programming order is: write zero to the length, then the upper start word, then the lower start word, then the nonzero length. Any write to a start word or to the length drops a running waveform and sends the channel back to waiting for its start time. If the time base is already past the start value, the channel starts again straight away.

Top module: `tpg_channel`

## Requirements
- R1: After reset the length is zero, the polarity bit is clear, and `pulse_out` is 0.
- R2: While the length register (address 1) holds zero, the internal waveform stays inactive and the output stays at its idle level, whatever the time base does.
- R3: The time base is registered on each rising clock edge. The waveform goes active on the next edge after the first edge that captures a `time_in` value greater than or equal to the 64-bit start time, so the delay is fixed at one cycle. Start words: address 2 holds time bits 31:0 and address 3 holds bits 63:32.
- R4: The start comparison is a true unsigned 64-bit comparison. A time whose low word exceeds the start's low word but whose high word is smaller does not start the channel.
- R5: With length L ≥ 2, active edges repeat every L cycles. The waveform stays active for L − floor(L/2) cycles and inactive for floor(L/2) cycles.
- R6: A write to address 1, 2 or 3 forces the waveform inactive on that same edge and puts the channel back into waiting. This takes priority over a toggle or a start due on that edge. If the time base already meets the start value, the channel starts on the next edge.
- R7: With length 1, the waveform stays active without a break once it has started.
- R8: Address 4 takes a signed 8-bit two's complement nudge in data bits 7:0. It is added once to the next inactive phase that begins after the write. The adjusted phase is never shorter than one cycle. A restart discards a nudge that has not been used yet.
- R9: Bit 0 of address 0 inverts the output: `pulse_out` = waveform XOR bit. Writing it does not restart the channel.
- R10: Writes to addresses 5, 6 and 7 change nothing, not even the running waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| time_in | input | 64 | Shared nanosecond time base |
| pulse_out | output | 1 | Periodic output after polarity |

## Verification
A register write that restarts the channel can arrive on the same edge as a scheduled toggle or start. Writing the same value back can also restart the channel. The bench provokes these collisions by timing writes of the start word and of the length to land exactly on the cycle where the scoreboard predicts an active edge. The expected result is that the edge is withheld: a re-armed channel whose start time has already passed starts one cycle later, and a disabled one stays idle. A nudge written during an active phase shows that the adjustment reaches exactly one later inactive phase.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   typedef enum logic [2:0] {
      RA_CTRL   = 3'd0,
      RA_LEN    = 3'd1,
      RA_CMP_LO = 3'd2,
      RA_CMP_HI = 3'd3,
      RA_NUDGE  = 3'd4
   } reg_addr_e;

   typedef enum logic [0:0] {
      ST_WAIT = 1'b0,
      ST_RUN  = 1'b1
   } chan_state_e;

endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
   import tpg_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned TIME_W  = 64,
   parameter int unsigned LEN_W   = 32,
   parameter int unsigned NUDGE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [2:0]                wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [TIME_W-1:0]         cmp_val,
   output logic [LEN_W-1:0]          len_val,
   output logic                      invert,
   output logic                      nudge_wr,
   output logic signed [NUDGE_W-1:0] nudge_val,
   output logic                      restart
);

   localparam int unsigned CMP_WORDS = TIME_W / DATA_W;

   logic [DATA_W-1:0] word_q [CMP_WORDS];
   logic [LEN_W-1:0]  len_q;
   logic              inv_q;
   logic              unused_ctrl_bits;

   assign unused_ctrl_bits = ^wr_data[DATA_W-1:1];

   for (genvar w = 0; w < CMP_WORDS; w++) begin : g_cmpw
      localparam logic [2:0] WADDR = 3'(int'(RA_CMP_LO) + w);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[w] <= '0;
         end else if (wr_en && wr_addr == WADDR) begin
            word_q[w] <= wr_data;
         end
      end
      assign cmp_val[w*DATA_W +: DATA_W] = word_q[w];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         inv_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == RA_LEN)  len_q <= wr_data[LEN_W-1:0];
         if (wr_addr == RA_CTRL) inv_q <= wr_data[0];
      end
   end

   assign len_val   = len_q;
   assign invert    = inv_q;
   assign nudge_wr  = wr_en && (wr_addr == RA_NUDGE);
   assign nudge_val = $signed(wr_data[NUDGE_W-1:0]);
   assign restart   = wr_en && (wr_addr == RA_LEN ||
                                wr_addr == RA_CMP_LO ||
                                wr_addr == RA_CMP_HI);

endmodule

// File: rtl/tpg_time_cmp.sv
module tpg_time_cmp #(
   parameter int unsigned TIME_W  = 64,
   parameter int unsigned SLICE_W = 16,
   parameter int unsigned STYLE   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_in,
   input  logic [TIME_W-1:0] cmp_val,
   output logic              ge
);

   localparam int unsigned N_SL = TIME_W / SLICE_W;

   logic [TIME_W-1:0] time_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_q <= '0;
      else        time_q <= time_in;
   end

   if (STYLE == 0) begin : g_flat
      assign ge = (time_q >= cmp_val);
   end else begin : g_tree
      logic [N_SL:0] ge_chain;
      assign ge_chain[0] = 1'b1;
      for (genvar s = 0; s < N_SL; s++) begin : g_sl
         logic [SLICE_W-1:0] t_s;
         logic [SLICE_W-1:0] c_s;
         assign t_s = time_q[s*SLICE_W +: SLICE_W];
         assign c_s = cmp_val[s*SLICE_W +: SLICE_W];
         assign ge_chain[s+1] = (t_s > c_s) | ((t_s == c_s) & ge_chain[s]);
      end
      assign ge = ge_chain[N_SL];

      // R4: the sliced chain must agree with a flat 64-bit comparison
      assert_tree_vs_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ge == (time_q >= cmp_val));
   end

endmodule

// File: rtl/tpg_period.sv
module tpg_period
   import tpg_pkg::*;
#(
   parameter int unsigned LEN_W   = 32,
   parameter int unsigned NUDGE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      restart,
   input  logic [LEN_W-1:0]          len_val,
   input  logic                      cmp_ge,
   input  logic                      nudge_wr,
   input  logic signed [NUDGE_W-1:0] nudge_val,
   output logic                      active
);

   localparam int unsigned EXT_W = LEN_W + 2;
   localparam logic signed [EXT_W-1:0] ONE_S = EXT_W'(1);

   chan_state_e               state_q;
   logic                      active_q;
   logic [LEN_W-1:0]          cnt_q;
   logic [LEN_W-1:0]          lim_q;
   logic signed [NUDGE_W-1:0] pend_q;

   logic [LEN_W-1:0]          hi_len;
   logic [LEN_W-1:0]          lo_len;
   logic signed [EXT_W-1:0]   lo_eff;
   logic [LEN_W-1:0]          lo_lim;
   logic                      enabled;
   logic                      run_q;
   logic                      phase_end;
   logic                      take_nudge;

   assign lo_len  = len_val >> 1;
   assign hi_len  = len_val - lo_len;
   assign enabled = (len_val != '0);
   assign run_q   = (state_q == ST_RUN);
   assign lo_eff  = $signed({2'b00, lo_len}) +
                    $signed({{(EXT_W-NUDGE_W){pend_q[NUDGE_W-1]}}, pend_q});
   assign lo_lim  = (lo_eff < ONE_S) ? '0 : (lo_eff[LEN_W-1:0] - LEN_W'(1));

   assign phase_end  = run_q && (cnt_q == lim_q);
   assign take_nudge = !restart && phase_end && active_q && (lo_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (nudge_wr) begin
         pend_q <= nudge_val;
      end else if (restart || take_nudge) begin
         pend_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_WAIT;
         active_q <= 1'b0;
         cnt_q    <= '0;
         lim_q    <= '0;
      end else if (restart) begin
         state_q  <= ST_WAIT;
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         case (state_q)
            ST_WAIT: begin
               if (enabled && cmp_ge) begin
                  state_q  <= ST_RUN;
                  active_q <= 1'b1;
                  cnt_q    <= '0;
                  lim_q    <= hi_len - LEN_W'(1);
               end
            end
            ST_RUN: begin
               if (cnt_q == lim_q) begin
                  if (active_q) begin
                     if (lo_len != '0) begin
                        active_q <= 1'b0;
                        cnt_q    <= '0;
                        lim_q    <= lo_lim;
                     end
                  end else begin
                     active_q <= 1'b1;
                     cnt_q    <= '0;
                     lim_q    <= hi_len - LEN_W'(1);
                  end
               end else begin
                  cnt_q <= cnt_q + LEN_W'(1);
               end
            end
            default: state_q <= ST_WAIT;
         endcase
      end
   end

   assign active = active_q;

   // R2: a zero length never coexists with an active waveform
   assert_len_zero_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (len_val == '0) |-> !active_q);

   // R3: entering the run state requires the registered time to meet the start
   assert_start_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(cmp_ge));

   // R5: the phase counter never passes its limit
   assert_count_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= lim_q));

   // R6: a restart leaves the waveform inactive on the following cycle
   assert_restart_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !active_q);

   // R7: length one holds the waveform active while running
   assert_len_one_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && active_q && len_val == LEN_W'(1) && !restart) |=> active_q);

endmodule

// File: rtl/tpg_channel.sv
module tpg_channel
   import tpg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TIME_W    = 64,
   parameter int unsigned LEN_W     = 32,
   parameter int unsigned NUDGE_W   = 8,
   parameter int unsigned SLICE_W   = 16,
   parameter int unsigned CMP_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [TIME_W-1:0] time_in,
   output logic              pulse_out
);

   if (TIME_W != 2 * DATA_W) begin : g_bad_time_w
      $error("tpg_channel: TIME_W must be twice DATA_W");
   end
   if (LEN_W > DATA_W || LEN_W < 2) begin : g_bad_len_w
      $error("tpg_channel: LEN_W must lie in 2..DATA_W");
   end
   if (NUDGE_W >= LEN_W || NUDGE_W < 2) begin : g_bad_nudge_w
      $error("tpg_channel: NUDGE_W must lie in 2..LEN_W-1");
   end
   if (SLICE_W == 0 || (TIME_W % SLICE_W) != 0) begin : g_bad_slice_w
      $error("tpg_channel: SLICE_W must divide TIME_W");
   end
   if (CMP_STYLE > 1) begin : g_bad_style
      $error("tpg_channel: CMP_STYLE must be 0 or 1");
   end

   logic [TIME_W-1:0]         cmp_val;
   logic [LEN_W-1:0]          len_val;
   logic                      invert;
   logic                      nudge_wr;
   logic signed [NUDGE_W-1:0] nudge_val;
   logic                      restart;
   logic                      cmp_ge;
   logic                      active;

   tpg_regs #(
      .DATA_W  (DATA_W),
      .TIME_W  (TIME_W),
      .LEN_W   (LEN_W),
      .NUDGE_W (NUDGE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cmp_val   (cmp_val),
      .len_val   (len_val),
      .invert    (invert),
      .nudge_wr  (nudge_wr),
      .nudge_val (nudge_val),
      .restart   (restart)
   );

   tpg_time_cmp #(
      .TIME_W  (TIME_W),
      .SLICE_W (SLICE_W),
      .STYLE   (CMP_STYLE)
   ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .time_in (time_in),
      .cmp_val (cmp_val),
      .ge      (cmp_ge)
   );

   tpg_period #(
      .LEN_W   (LEN_W),
      .NUDGE_W (NUDGE_W)
   ) u_period (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .len_val   (len_val),
      .cmp_ge    (cmp_ge),
      .nudge_wr  (nudge_wr),
      .nudge_val (nudge_val),
      .active    (active)
   );

   assign pulse_out = active ^ invert;

   // R9: a polarity write alone does not disturb the waveform
   assert_ctrl_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_CTRL) |-> !restart);

endmodule

// File: tb/tpg_channel_tb.sv
module tpg_channel_tb;
   import tpg_pkg::*;

   localparam longint unsigned T0 = 64'h0000_0001_FFFF_FF00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [63:0] time_in = '0;
   logic        pulse_out;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;
   bit mon_on = 0;
   logic prev_out = 1'b0;

   int    exp_cyc [$];
   bit    exp_lvl [$];
   string exp_tag [$];

   tpg_channel u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .time_in   (time_in),
      .pulse_out (pulse_out)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) time_in <= T0 + 64'(cyc);

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(int c, bit lvl, string tag);
      exp_cyc.push_back(c);
      exp_lvl.push_back(lvl);
      exp_tag.push_back(tag);
   endtask

   task automatic go(int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic wr(int w, logic [2:0] a, logic [31:0] d);
      go(w - 1);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic program_start(int w, longint unsigned t);
      wr(w, RA_CMP_HI, t[63:32]);
      wr(w + 1, RA_CMP_LO, t[31:0]);
   endtask

   // monitor: every output change must match the next scoreboard item
   always @(negedge clk) begin
      if (mon_on) begin
         if (pulse_out !== prev_out) begin
            if (exp_cyc.size() == 0) begin
               check(1'b0, "R2", "unexpected output change at cycle", cyc, -1);
            end else begin
               int    ec;
               bit    el;
               string et;
               ec = exp_cyc.pop_front();
               el = exp_lvl.pop_front();
               et = exp_tag.pop_front();
               check(cyc == ec, et, "edge cycle", cyc, ec);
               check(pulse_out == el, et, "edge level", longint'(pulse_out), longint'(el));
            end
         end
         prev_out = pulse_out;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      check(1'b0, "R1", "watchdog expired at cycle", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pulse_out == 1'b0, "R1", "output during reset", longint'(pulse_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pulse_out == 1'b0, "R1", "output after reset", longint'(pulse_out), 0);
      prev_out = pulse_out;
      mon_on = 1;

      // A: high start word matters (R4), period 10 (R5, R3), disable on an edge (R6, R2)
      wr(10, RA_LEN, 32'd0);
      program_start(11, T0 + 64'h200);
      for (int k = 0; k < 4; k++) begin
         push(514 + 10 * k, 1'b1, "R3_R4_R5");
         push(519 + 10 * k, 1'b0, "R5");
      end
      wr(13, RA_LEN, 32'd10);
      go(100);
      check(pulse_out == 1'b0, "R4", "no start from low word alone", longint'(pulse_out), 0);
      wr(554, RA_LEN, 32'd0);
      go(599);
      check(pulse_out == 1'b0, "R2", "idle with zero length", longint'(pulse_out), 0);

      // B: odd length 7, re-arm collides with a rise, cancel while active (R5, R6)
      program_start(601, T0 + 64'd700);
      push(702, 1'b1, "R5"); push(706, 1'b0, "R5");
      push(709, 1'b1, "R5"); push(713, 1'b0, "R5");
      push(717, 1'b1, "R6"); push(721, 1'b0, "R5");
      push(724, 1'b1, "R5"); push(726, 1'b0, "R6");
      wr(603, RA_LEN, 32'd7);
      wr(716, RA_CMP_LO, 32'(T0 + 64'd700));
      wr(726, RA_LEN, 32'd0);

      // C: length one stays active (R7)
      program_start(750, T0 + 64'd800);
      push(802, 1'b1, "R7");
      push(820, 1'b0, "R7");
      wr(752, RA_LEN, 32'd1);
      go(815);
      check(pulse_out == 1'b1, "R7", "held active", longint'(pulse_out), 1);
      wr(820, RA_LEN, 32'd0);

      // D: nudge +3 then -7 clamped to one cycle (R8)
      program_start(850, T0 + 64'd900);
      push(902, 1'b1, "R8"); push(907, 1'b0, "R8");
      push(912, 1'b1, "R8"); push(917, 1'b0, "R8");
      push(925, 1'b1, "R8"); push(930, 1'b0, "R8");
      push(935, 1'b1, "R8"); push(940, 1'b0, "R8");
      push(941, 1'b1, "R8"); push(946, 1'b0, "R8");
      push(951, 1'b1, "R8"); push(953, 1'b0, "R6");
      wr(852, RA_LEN, 32'd10);
      wr(913, RA_NUDGE, 32'd3);
      wr(936, RA_NUDGE, 32'h0000_00F9);
      wr(953, RA_LEN, 32'd0);

      // E: polarity (R9) and unused addresses (R10)
      push(1000, 1'b1, "R9");
      wr(1000, RA_CTRL, 32'd1);
      wr(1001, 3'd5, 32'hFFFF_FFFF);
      wr(1002, 3'd6, 32'hFFFF_FFFF);
      wr(1003, 3'd7, 32'hFFFF_FFFF);
      program_start(1010, T0 + 64'd1100);
      push(1102, 1'b0, "R9"); push(1105, 1'b1, "R9");
      push(1108, 1'b0, "R10"); push(1110, 1'b1, "R9");
      push(1111, 1'b0, "R9");
      wr(1012, RA_LEN, 32'd6);
      wr(1107, 3'd5, 32'hFFFF_FFFF);
      check(pulse_out == 1'b1, "R10", "output after ignored write", longint'(pulse_out), 1);
      wr(1110, RA_CTRL, 32'd0);
      wr(1112, RA_LEN, 32'd0);

      go(1150);
      check(exp_cyc.size() == 0, "R6", "scoreboard items left", exp_cyc.size(), 0);
      check(pulse_out == 1'b0, "R2", "final idle level", longint'(pulse_out), 0);
      finish_run();
   end

endmodule